// File: doc/BRIEF.md
# Parallel Port Strobe Handshake Controller

A parallel port of `WIDTH` pins (eight by default) with two handshake lines: a strobe input whose active edge is selectable, and a ready strobe output. The host reaches four registers through a simple synchronous bus. The registers are a control/status word, a direction mask, a static data register and a latched data register. On the pad side the port drives separate output and output-enable vectors and samples an input vector.

There are four modes. In static mode the pins are plain I/O. In input handshake mode the port raises its ready strobe, captures the pins on the active strobe-input edge and drops ready. Ready rises again only when the host reads the latched register. In output handshake mode a host write to the latched register presents new data and raises ready, and the acknowledge edge drops it. In the tri-state output variant the pins whose direction bits are clear are driven only while the strobe input is at its active level. During that window all pins are driven. Ready falls on the trailing edge of the strobe input.

Top module: `pport_hs_ctrl`

## Requirements
- R1: After reset the mode is static, the control register reads 0x04 (rising edge active, strobe output not inverted), every pin is an input (`pin_oe` all zero), the strobe output is 0 and the latched register reads 0.
- R2: Register addresses are 0 control/status, 1 direction, 2 static data, 3 latched data. In static mode `pin_out` equals the static data register and `pin_oe` equals the direction mask. A read of address 2 returns `pin_in` on bits whose direction bit is 0 and the data register on bits whose direction bit is 1. The strobe output stays at its negated level.
- R3: The strobe input passes through two synchronizing flops and one edge flop. Control bit 2 set makes the rising edge active, and clear makes the falling edge active. A change applied before rising clock edge k takes effect on the state at edge k+2.
- R4: Control bits [1:0] hold the mode: 00 static, 01 input handshake, 10 output handshake, 11 tri-state output. In input handshake mode an active edge copies `pin_in` into the latched register and negates ready.
- R5: In input handshake mode ready is reasserted only by a read of address 3. Reads of other addresses leave it negated. An active edge in the same cycle as the read wins.
- R6: In output handshake mode a write to address 3 loads both the latched and static data registers and asserts ready. The next active strobe-input edge negates ready, and `pin_oe` follows the direction mask.
- R7: In tri-state output mode a write to address 3 asserts ready. While the synchronized strobe input is at its active level every bit of `pin_oe` is 1, and otherwise `pin_oe` equals the direction mask. Ready is negated on the trailing edge and not on the active edge.
- R8: Control bit 3 inverts the strobe output: `stb_out` equals ready XOR bit 3.
- R9: Status flag (control bit 7) sets on each active edge in any mode other than static. It is cleared by a read of address 0 that returns it set, followed by a read or write of address 3. An access to address 3 without that prior read leaves it set.
- R10: A control write sets ready to 1 exactly when the new mode is input handshake, and clears it otherwise. Bit 7 of the written value has no effect on the flag.
- R11: A read of the latched register with no new active edge returns the previously latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data for `reg_addr`, combinational |
| pin_in | input | WIDTH | Pad input levels |
| pin_out | output | WIDTH | Pad output levels |
| pin_oe | output | WIDTH | Pad output enables |
| stb_in | input | 1 | Strobe/acknowledge input, asynchronous |
| stb_out | output | 1 | Ready strobe output |

## Verification
The hardest case to reach is the two-step clearing of the status flag, because it interacts with the input-handshake rearm. A read of the latched register both rearms ready and may or may not clear the flag, depending on whether a status read came first. The stimulus therefore runs one strobe edge with the latched read before the status read, and another with the reverse order. It checks ready and the flag after each access. The synchronizer latency is also pinned down by sampling `stb_out` and `pin_oe` on each of the three clock edges after the strobe input changes, in both edge polarities.

// File: rtl/pport_pkg.sv
// Shared definitions for the parallel port handshake controller.
// Assumes a 2-bit register address space.
package pport_pkg;
    typedef enum logic [1:0] {
        PM_STATIC  = 2'b00,
        PM_IN_HS   = 2'b01,
        PM_OUT_HS  = 2'b10,
        PM_OUT_TRI = 2'b11
    } pmode_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_DIR   = 2'd1;
    localparam logic [1:0] ADDR_DATA  = 2'd2;
    localparam logic [1:0] ADDR_LATCH = 2'd3;

    localparam int CTRL_BIT_RISE = 2;
    localparam int CTRL_BIT_INV  = 3;
    localparam int CTRL_BIT_FLAG = 7;
endpackage

// File: rtl/pport_strobe_sync.sv
// Synchronizes the asynchronous strobe input through STAGES flops, keeps one
// more flop for edge detection, and reports the active level plus active
// and trailing edges under the selected polarity.
// Assumes STAGES >= 2 and rise_sel driven from a register in the clk domain.
module pport_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_raw,
    input  logic rise_sel,
    output logic act_level,
    output logic act_edge,
    output logic trail_edge
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              prev_level;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw pad level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= strobe_raw;
            end
        end else begin : g_next
            // Later stages shift the sample along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    // Map the raw levels onto the selected active polarity.
    always_comb begin
        act_level  = rise_sel ? chain_q[LAST] : ~chain_q[LAST];
        prev_level = rise_sel ? prev_q : ~prev_q;
        act_edge   = act_level & ~prev_level;
        trail_edge = ~act_level & prev_level;
    end

    // An active edge cannot repeat on the next cycle unless the polarity changed.
    assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_edge |=> (!act_edge || rise_sel != $past(rise_sel)));
endmodule

// File: rtl/pport_hs_seq.sv
// Handshake sequencer: owns the ready strobe and the status flag with its
// two-step clear (status read, then latched-register access).
// Assumes one register access per cycle.
module pport_hs_seq
    import pport_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  pmode_t mode,
    input  pmode_t wmode,
    input  logic   ctrl_wr,
    input  logic   ctrl_rd,
    input  logic   lat_wr,
    input  logic   lat_rd,
    input  logic   act_edge,
    input  logic   trail_edge,
    output logic   ready,
    output logic   flag
);
    logic arm_q;
    logic flag_set;
    logic lat_acc;

    assign flag_set = act_edge && (mode != PM_STATIC);
    assign lat_acc  = lat_wr || lat_rd;

    // Ready strobe sequencing per mode; a control write re-initializes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
        end else if (ctrl_wr) begin
            ready <= (wmode == PM_IN_HS);
        end else begin
            unique case (mode)
                PM_IN_HS: begin
                    if (act_edge)    ready <= 1'b0;
                    else if (lat_rd) ready <= 1'b1;
                end
                PM_OUT_HS: begin
                    if (lat_wr)        ready <= 1'b1;
                    else if (act_edge) ready <= 1'b0;
                end
                PM_OUT_TRI: begin
                    if (lat_wr)          ready <= 1'b1;
                    else if (trail_edge) ready <= 1'b0;
                end
                default: ready <= 1'b0;
            endcase
        end
    end

    // Status flag: set wins over the armed clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag <= 1'b0;
        else if (flag_set)       flag <= 1'b1;
        else if (arm_q && lat_acc) flag <= 1'b0;
    end

    // Arm the clear when the host has seen the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)               arm_q <= 1'b0;
        else if (ctrl_rd && flag) arm_q <= 1'b1;
        else if (lat_acc)         arm_q <= 1'b0;
    end

    assert_in_edge_drops_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_IN_HS && !ctrl_wr && act_edge) |=> !ready);
    assert_in_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_IN_HS && !ctrl_wr && !act_edge && lat_rd) |=> ready);
    assert_out_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_OUT_HS && !ctrl_wr && !lat_wr && act_edge) |=> !ready);
    assert_tri_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_OUT_TRI && !ctrl_wr && ready && !trail_edge) |=> ready);
    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> flag);
endmodule

// File: rtl/pport_hs_ctrl.sv
// Parallel port with strobe handshake. Holds the host-visible registers,
// decodes accesses and drives the pad vectors; sequencing lives in
// pport_hs_seq and strobe conditioning in pport_strobe_sync.
// Assumes WIDTH >= 8 (control word occupies bits 7:0) and one access per cycle.
module pport_hs_ctrl
    import pport_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    input  logic             stb_in,
    output logic             stb_out
);
    pmode_t           mode_q;
    logic             rise_q;
    logic             inv_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] latch_q;
    logic             ctrl_wr, ctrl_rd, dir_wr, data_wr, lat_wr, lat_rd;
    logic             act_level, act_edge, trail_edge;
    logic             ready, flag;
    pmode_t           wmode;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign ctrl_rd = reg_rd && (reg_addr == ADDR_CTRL);
    assign dir_wr  = reg_wr && (reg_addr == ADDR_DIR);
    assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
    assign lat_wr  = reg_wr && (reg_addr == ADDR_LATCH);
    assign lat_rd  = reg_rd && (reg_addr == ADDR_LATCH);
    assign wmode   = pmode_t'(reg_wdata[1:0]);

    pport_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_raw (stb_in),
        .rise_sel   (rise_q),
        .act_level  (act_level),
        .act_edge   (act_edge),
        .trail_edge (trail_edge)
    );

    pport_hs_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .wmode      (wmode),
        .ctrl_wr    (ctrl_wr),
        .ctrl_rd    (ctrl_rd),
        .lat_wr     (lat_wr),
        .lat_rd     (lat_rd),
        .act_edge   (act_edge),
        .trail_edge (trail_edge),
        .ready      (ready),
        .flag       (flag)
    );

    // Control fields: mode, edge polarity and strobe inversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_STATIC;
            rise_q <= 1'b1;
            inv_q  <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q <= wmode;
            rise_q <= reg_wdata[CTRL_BIT_RISE];
            inv_q  <= reg_wdata[CTRL_BIT_INV];
        end
    end

    // Direction mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (dir_wr) dir_q <= reg_wdata;
    end

    // Static data register; latched-register writes also present new data.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (data_wr || lat_wr) data_q <= reg_wdata;
    end

    // Latched register: input capture on active edge beats a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                latch_q <= '0;
        else if (mode_q == PM_IN_HS && act_edge)   latch_q <= pin_in;
        else if (lat_wr)                           latch_q <= reg_wdata;
    end

    // Pad drive: tri-state variant opens every pin during the active window.
    always_comb begin
        pin_out = data_q;
        if (mode_q == PM_OUT_TRI && act_level) pin_oe = '1;
        else                                   pin_oe = dir_q;
        stb_out = ready ^ inv_q;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[1:0]           = mode_q;
                reg_rdata[CTRL_BIT_RISE] = rise_q;
                reg_rdata[CTRL_BIT_INV]  = inv_q;
                reg_rdata[CTRL_BIT_FLAG] = flag;
            end
            ADDR_DIR:  reg_rdata = dir_q;
            ADDR_DATA: reg_rdata = (pin_in & ~dir_q) | (data_q & dir_q);
            default:   reg_rdata = latch_q;
        endcase
    end

    assert_oe_covers_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_q) == dir_q);
    assert_static_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_STATIC) |-> (stb_out == inv_q));
    assert_in_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_IN_HS && act_edge) |=> (latch_q == $past(pin_in)));
endmodule

// File: tb/test_pport_hs_ctrl.sv
module test_pport_hs_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe;
    logic       stb_in = 1'b0;
    logic       stb_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pport_hs_ctrl i_pport_hs_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .stb_in(stb_in), .stb_out(stb_out)
    );

    // Reference model state.
    bit   m_s1, m_s2, m_sd;
    logic [1:0] m_mode;
    bit   m_rise, m_inv, m_ready, m_flag, m_arm;
    logic [7:0] m_dir, m_data, m_latch;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin : model
        bit lvl, plvl, edge_a, edge_t, lat_acc;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_sd = 0;
            m_mode = 2'b00; m_rise = 1; m_inv = 0;
            m_ready = 0; m_flag = 0; m_arm = 0;
            m_dir = 0; m_data = 0; m_latch = 0;
        end else begin
            lvl    = m_rise ? m_s2 : !m_s2;
            plvl   = m_rise ? m_sd : !m_sd;
            edge_a = lvl && !plvl;
            edge_t = !lvl && plvl;
            lat_acc = (reg_addr == 2'd3) && (reg_rd || reg_wr);
            // ready
            if (reg_wr && reg_addr == 2'd0) m_ready = (reg_wdata[1:0] == 2'b01);
            else if (m_mode == 2'b01) begin
                if (edge_a) m_ready = 0;
                else if (reg_rd && reg_addr == 2'd3) m_ready = 1;
            end else if (m_mode == 2'b10) begin
                if (reg_wr && reg_addr == 2'd3) m_ready = 1;
                else if (edge_a) m_ready = 0;
            end else if (m_mode == 2'b11) begin
                if (reg_wr && reg_addr == 2'd3) m_ready = 1;
                else if (edge_t) m_ready = 0;
            end else m_ready = 0;
            // flag and arm (arm uses the flag value before this edge)
            if (reg_rd && reg_addr == 2'd0 && m_flag) m_arm_next(1);
            else if (lat_acc) m_arm_next(0);
            else m_arm_next(m_arm);
            if (edge_a && m_mode != 2'b00) m_flag = 1;
            else if (m_arm && lat_acc) m_flag = 0;
            m_arm = m_arm_n;
            // latch and data
            if (m_mode == 2'b01 && edge_a) m_latch = pin_in;
            else if (reg_wr && reg_addr == 2'd3) m_latch = reg_wdata;
            if (reg_wr && (reg_addr == 2'd2 || reg_addr == 2'd3)) m_data = reg_wdata;
            if (reg_wr && reg_addr == 2'd1) m_dir = reg_wdata;
            if (reg_wr && reg_addr == 2'd0) begin
                m_mode = reg_wdata[1:0]; m_rise = reg_wdata[2]; m_inv = reg_wdata[3];
            end
            m_sd = m_s2; m_s2 = m_s1; m_s1 = stb_in;
        end
    end

    bit m_arm_n;
    function automatic void m_arm_next(input bit v);
        m_arm_n = v;
    endfunction

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin : compare
        logic [7:0] e_rd, e_oe;
        if (rst_n && !done) begin
            unique case (reg_addr)
                2'd0: e_rd = {m_flag, 3'b000, m_inv, m_rise, m_mode};
                2'd1: e_rd = m_dir;
                2'd2: e_rd = (pin_in & ~m_dir) | (m_data & m_dir);
                default: e_rd = m_latch;
            endcase
            e_oe = (m_mode == 2'b11 && (m_rise ? m_s2 : !m_s2)) ? 8'hFF : m_dir;
            check("R8 stb_out", {7'd0, stb_out}, {7'd0, m_ready ^ m_inv});
            check("R7 pin_oe", pin_oe, e_oe);
            check("R2 pin_out", pin_out, m_data);
            check("R9 reg_rdata", reg_rdata, e_rd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); #1;
        reg_addr = a; reg_rd = 1;
        #1 v = reg_rdata;
        @(negedge clk); #1;
        reg_rd = 0;
    endtask

    task automatic stb(input logic v);
        @(negedge clk); #1;
        stb_in = v;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 stb_out", {7'd0, stb_out}, 8'h00);
        rd(2'd0, v); check("R1 ctrl", v, 8'h04);
        rd(2'd3, v); check("R11 latch at reset", v, 8'h00);
        // R2 static mode
        wr(2'd1, 8'h0F); wr(2'd2, 8'hA5); pin_in = 8'h3C;
        #1 check("R2 pin_out", pin_out, 8'hA5);
        check("R2 pin_oe", pin_oe, 8'h0F);
        rd(2'd2, v); check("R2 data mix", v, 8'h35);
        stb(1); repeat (3) @(negedge clk);
        rd(2'd0, v); check("R9 no flag in static", v, 8'h04);
        check("R2 stb_out negated", {7'd0, stb_out}, 8'h00);
        stb(0); repeat (3) @(negedge clk);
        // R4/R3 input handshake, rising edge
        wr(2'd0, 8'h05);
        check("R10 ready on input mode", {7'd0, stb_out}, 8'h01);
        pin_in = 8'h5A;
        stb(1);
        @(negedge clk); check("R3 edge k", {7'd0, stb_out}, 8'h01);
        @(negedge clk); check("R3 edge k+1", {7'd0, stb_out}, 8'h01);
        @(negedge clk); check("R3 edge k+2", {7'd0, stb_out}, 8'h00);
        rd(2'd2, v); check("R5 no rearm on data read", {7'd0, stb_out}, 8'h00);
        rd(2'd0, v); check("R9 flag set", v, 8'h85);
        rd(2'd3, v); check("R4 latched value", v, 8'h5A);
        check("R5 rearm on latch read", {7'd0, stb_out}, 8'h01);
        rd(2'd0, v); check("R9 flag cleared", v, 8'h05);
        pin_in = 8'h11;
        rd(2'd3, v); check("R11 previous latch", v, 8'h5A);
        // falling edge, latch access without status read
        wr(2'd0, 8'h01); pin_in = 8'hC7;
        stb(0); repeat (3) @(negedge clk);
        check("R3 falling edge", {7'd0, stb_out}, 8'h00);
        rd(2'd3, v); check("R4 falling capture", v, 8'hC7);
        rd(2'd0, v); check("R9 flag kept without status read", v, 8'h81);
        rd(2'd3, v); rd(2'd0, v); check("R9 flag cleared after sequence", v, 8'h01);
        // R10/R6 output handshake
        wr(2'd0, 8'h86);
        rd(2'd0, v); check("R10 flag bit ignored", v, 8'h06);
        check("R10 ready clear in output mode", {7'd0, stb_out}, 8'h00);
        wr(2'd3, 8'hC3);
        check("R6 pin_out", pin_out, 8'hC3);
        check("R6 ready", {7'd0, stb_out}, 8'h01);
        check("R6 pin_oe", pin_oe, 8'h0F);
        stb(1); repeat (3) @(negedge clk);
        check("R6 ack", {7'd0, stb_out}, 8'h00);
        stb(0); repeat (3) @(negedge clk);
        // R7 tri-state variant
        wr(2'd1, 8'h00); wr(2'd0, 8'h07); wr(2'd3, 8'h99);
        check("R7 ready", {7'd0, stb_out}, 8'h01);
        check("R7 oe idle", pin_oe, 8'h00);
        stb(1); repeat (2) @(negedge clk);
        check("R7 oe active", pin_oe, 8'hFF);
        @(negedge clk); check("R7 ready held on active edge", {7'd0, stb_out}, 8'h01);
        stb(0); repeat (2) @(negedge clk);
        check("R7 oe released", pin_oe, 8'h00);
        @(negedge clk); check("R7 trailing drop", {7'd0, stb_out}, 8'h00);
        // R8 inversion
        wr(2'd0, 8'h0C); check("R8 static inverted", {7'd0, stb_out}, 8'h01);
        wr(2'd0, 8'h0D); check("R8 ready inverted", {7'd0, stb_out}, 8'h00);
        // mixed traffic in input mode, compared against the model
        wr(2'd0, 8'h05);
        for (int i = 0; i < 24; i++) begin
            pin_in = 8'($urandom);
            stb(~stb_in);
            repeat (i % 4) @(negedge clk);
            if (i % 3 == 0) rd(2'd0, v);
            rd(2'd3, v);
        end
        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule